// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block produces a pulse-width modulated waveform with up to 10 bits of duty resolution. An 8-bit timer is extended by two fine sub-count bits into a 10-bit time base. The fine bits come from a clock-phase counter, or from the top of the prescaler when the prescaler is in use. The timer is compared against an 8-bit period value. The 10-bit time base is compared against a shadow copy of the duty word.

The duty word is built from an 8-bit high byte, which supplies the upper bits, and a 2-bit low field, which supplies the lowest bits. It is copied into the shadow register only at a period boundary. That is the same tick in which the timer wraps to zero and the output goes high. The shadow value can be observed but cannot be written, so a duty change made part-way through a period takes effect cleanly at the next boundary.

A nonzero control word gives the block ownership of the output pin. Clearing the control word to zero releases the pin and forces the output low.

Top module: `dbuf_pwm`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pwm_o` and `shadow_o` are 0. While reset is asserted `pin_oe_o` is 0.
- R2: A period lasts (period_i+1)*4*P clocks, where P is the prescale factor. The first rising edge of `pwm_o` comes exactly one period after reset release.
- R3: For a duty word D with 0 < D < (period_i+1)*4, `pwm_o` stays high for D*P clocks of each period, counted from the boundary.
- R4: A duty word of 0 keeps `pwm_o` low for the whole period.
- R5: A duty word of (period_i+1)*4 or more keeps `pwm_o` high for the whole period.
- R6: `shadow_o` takes the value {duty_hi_i, duty_lo_i} only at a period boundary. Duty changes made mid-period do not alter `shadow_o` or the waveform until the next boundary.
- R7: `psc_sel_i` selects P. The value 0 gives P=1, 1 gives P=4, and 2 or 3 gives P=16.
- R8: One clock after `ctrl_i` becomes 0, both `pin_oe_o` and `pwm_o` are 0. After `ctrl_i` becomes nonzero again, `pin_oe_o` returns one clock later, but `pwm_o` stays low until the next period boundary.
- R9: While `run_i` is 0, the time base, `pwm_o` and `shadow_o` hold their values. The waveform resumes where it stopped.
- R10: `pwm_o` rises only at a period boundary. When the duty word is 0, the set action at the boundary does not produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 4 | Control word; zero releases the pin |
| run_i | input | 1 | Time base enable |
| period_i | input | 8 | Timer value of the last tick in a period |
| duty_hi_i | input | 8 | Upper 8 bits of the duty word |
| duty_lo_i | input | 2 | Lower 2 bits of the duty word |
| psc_sel_i | input | 2 | Prescale select |
| pwm_o | output | 1 | PWM output |
| pin_oe_o | output | 1 | Pin ownership / output enable |
| shadow_o | output | 10 | Latched duty word in use |

## Verification
A corrupted shadow register shows up within the current period. `shadow_o` changes away from a boundary, and the falling edge of `pwm_o` moves to a different clock. A faulty timer or prescaler shows up in the first period after reset, because the first rising edge arrives at the wrong clock count. A broken set/clear priority shows up as a one-clock pulse in a zero-duty period, or as a missing fall in a period with a short duty.

// File: rtl/dbuf_pwm_pkg.sv
package dbuf_pwm_pkg;
   localparam int unsigned TMR_W_DFLT    = 8;
   localparam int unsigned SUB_W_DFLT    = 2;
   localparam int unsigned PRE_STEP_DFLT = 2;
   localparam int unsigned NUM_PRE_DFLT  = 3;
   localparam int unsigned SEL_W_DFLT    = 2;
   localparam int unsigned CTRL_W_DFLT   = 4;
endpackage

// File: rtl/dbuf_pwm_timebase.sv
module dbuf_pwm_timebase #(
   parameter int unsigned TMR_W    = dbuf_pwm_pkg::TMR_W_DFLT,
   parameter int unsigned SUB_W    = dbuf_pwm_pkg::SUB_W_DFLT,
   parameter int unsigned PRE_STEP = dbuf_pwm_pkg::PRE_STEP_DFLT,
   parameter int unsigned NUM_PRE  = dbuf_pwm_pkg::NUM_PRE_DFLT,
   parameter int unsigned SEL_W    = dbuf_pwm_pkg::SEL_W_DFLT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_i,
   input  logic [SEL_W-1:0]         sel_i,
   input  logic [TMR_W-1:0]         period_i,
   output logic                     prd_evt_o,
   output logic [TMR_W+SUB_W-1:0]   base_nxt_o
);
   localparam int unsigned FINE_W = SUB_W + PRE_STEP * (NUM_PRE - 1);
   localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(NUM_PRE - 1);

   logic [FINE_W-1:0] fine_q, fine_d;
   logic [TMR_W-1:0]  tmr_q, tmr_d;
   logic [FINE_W-1:0] lim_w [NUM_PRE];
   logic [SUB_W-1:0]  sub_w [NUM_PRE];
   logic [SEL_W-1:0]  idx;
   logic              tick;

   // one limit / sub-field tap per prescale option
   generate
      for (genvar k = 0; k < NUM_PRE; k++) begin : g_psc
         localparam int unsigned SPAN_W = SUB_W + PRE_STEP * k;
         assign lim_w[k] = FINE_W'((64'd1 << SPAN_W) - 64'd1);
         assign sub_w[k] = fine_d[PRE_STEP*k +: SUB_W];
      end
   endgenerate

   assign idx       = (sel_i > SEL_TOP) ? SEL_TOP : sel_i;
   assign tick      = run_i && (fine_q >= lim_w[idx]);
   assign prd_evt_o = tick && (tmr_q == period_i);

   always_comb begin
      fine_d = fine_q;
      tmr_d  = tmr_q;
      if (tick) begin
         fine_d = '0;
         tmr_d  = prd_evt_o ? '0 : tmr_q + 1'b1;
      end else if (run_i) begin
         fine_d = fine_q + 1'b1;
      end
   end

   assign base_nxt_o = {tmr_d, sub_w[idx]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fine_q <= '0;
         tmr_q  <= '0;
      end else begin
         fine_q <= fine_d;
         tmr_q  <= tmr_d;
      end
   end
endmodule

// File: rtl/dbuf_pwm_shadow.sv
module dbuf_pwm_shadow #(
   parameter int unsigned DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] duty_i,
   output logic [DW-1:0] shadow_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow_o <= '0;
      else if (load_i) shadow_o <= duty_i;
   end
endmodule

// File: rtl/dbuf_pwm_outstage.sv
module dbuf_pwm_outstage #(
   parameter int unsigned DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active_i,
   input  logic          prd_evt_i,
   input  logic [DW-1:0] base_nxt_i,
   input  logic [DW-1:0] shadow_i,
   input  logic [DW-1:0] duty_i,
   output logic          pwm_o,
   output logic          oe_o
);
   logic out_q, oe_q;

   // set at the boundary wins over the duty match
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q <= active_i;
         if (!active_i)                   out_q <= 1'b0;
         else if (prd_evt_i)              out_q <= |duty_i;
         else if (base_nxt_i == shadow_i) out_q <= 1'b0;
      end
   end

   assign pwm_o = out_q;
   assign oe_o  = oe_q;
endmodule

// File: rtl/dbuf_pwm.sv
module dbuf_pwm #(
   parameter int unsigned TMR_W    = dbuf_pwm_pkg::TMR_W_DFLT,
   parameter int unsigned SUB_W    = dbuf_pwm_pkg::SUB_W_DFLT,
   parameter int unsigned PRE_STEP = dbuf_pwm_pkg::PRE_STEP_DFLT,
   parameter int unsigned NUM_PRE  = dbuf_pwm_pkg::NUM_PRE_DFLT,
   parameter int unsigned SEL_W    = dbuf_pwm_pkg::SEL_W_DFLT,
   parameter int unsigned CTRL_W   = dbuf_pwm_pkg::CTRL_W_DFLT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [CTRL_W-1:0]      ctrl_i,
   input  logic                   run_i,
   input  logic [TMR_W-1:0]       period_i,
   input  logic [TMR_W-1:0]       duty_hi_i,
   input  logic [SUB_W-1:0]       duty_lo_i,
   input  logic [SEL_W-1:0]       psc_sel_i,
   output logic                   pwm_o,
   output logic                   pin_oe_o,
   output logic [TMR_W+SUB_W-1:0] shadow_o
);
   localparam int unsigned DW = TMR_W + SUB_W;

   generate
      if (TMR_W < 2)                $error("dbuf_pwm: TMR_W too small");
      if (SUB_W < 1)                $error("dbuf_pwm: SUB_W must be >= 1");
      if (PRE_STEP < 1)             $error("dbuf_pwm: PRE_STEP must be >= 1");
      if (NUM_PRE < 1)              $error("dbuf_pwm: NUM_PRE must be >= 1");
      if (NUM_PRE > (1 << SEL_W))   $error("dbuf_pwm: SEL_W cannot reach all prescale options");
      if (CTRL_W < 1)               $error("dbuf_pwm: CTRL_W must be >= 1");
   endgenerate

   logic          prd_evt;
   logic [DW-1:0] base_nxt;
   logic [DW-1:0] duty_word;
   logic          active;

   assign duty_word = {duty_hi_i, duty_lo_i};
   assign active    = |ctrl_i;

   dbuf_pwm_timebase #(
      .TMR_W(TMR_W), .SUB_W(SUB_W), .PRE_STEP(PRE_STEP),
      .NUM_PRE(NUM_PRE), .SEL_W(SEL_W)
   ) u_tb (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .sel_i(psc_sel_i),
      .period_i(period_i), .prd_evt_o(prd_evt), .base_nxt_o(base_nxt)
   );

   dbuf_pwm_shadow #(.DW(DW)) u_shd (
      .clk(clk), .rst_n(rst_n), .load_i(prd_evt),
      .duty_i(duty_word), .shadow_o(shadow_o)
   );

   dbuf_pwm_outstage #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .active_i(active), .prd_evt_i(prd_evt),
      .base_nxt_i(base_nxt), .shadow_i(shadow_o), .duty_i(duty_word),
      .pwm_o(pwm_o), .oe_o(pin_oe_o)
   );
endmodule

// File: rtl/dbuf_pwm_chk.sv
module dbuf_pwm_chk #(
   parameter int unsigned DW     = 10,
   parameter int unsigned CTRL_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTRL_W-1:0] ctrl_i,
   input logic              run_i,
   input logic [DW-1:0]     duty_word,
   input logic              prd_evt,
   input logic              pwm_o,
   input logic              pin_oe_o,
   input logic [DW-1:0]     shadow_o
);
   p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prd_evt |=> (shadow_o == $past(duty_word)));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !prd_evt |=> $stable(shadow_o));

   p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_i == '0) |=> (!pin_oe_o && !pwm_o));

   p_rise_at_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_o) |-> $past(prd_evt));

   p_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (shadow_o == '0) |-> !pwm_o);

   p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && ctrl_i != '0) |=> ($stable(pwm_o) && $stable(shadow_o)));
endmodule

bind dbuf_pwm dbuf_pwm_chk #(.DW(TMR_W + SUB_W), .CTRL_W(CTRL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .run_i(run_i),
   .duty_word(duty_word), .prd_evt(prd_evt), .pwm_o(pwm_o),
   .pin_oe_o(pin_oe_o), .shadow_o(shadow_o)
);

// File: tb/dbuf_pwm_tb.sv
`timescale 1ns/1ps
module dbuf_pwm_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ctrl_i = 4'h0;
   logic       run_i = 1'b0;
   logic [7:0] period_i = 8'd0;
   logic [7:0] duty_hi_i = 8'd0;
   logic [1:0] duty_lo_i = 2'd0;
   logic [1:0] psc_sel_i = 2'd0;
   logic       pwm_o, pin_oe_o;
   logic [9:0] shadow_o;

   int n_chk = 0;
   int n_err = 0;
   int edge_n = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dbuf_pwm u_dut (
      .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .run_i(run_i),
      .period_i(period_i), .duty_hi_i(duty_hi_i), .duty_lo_i(duty_lo_i),
      .psc_sel_i(psc_sel_i), .pwm_o(pwm_o), .pin_oe_o(pin_oe_o),
      .shadow_o(shadow_o)
   );

   // {period, duty_hi, duty_lo, psc_sel, expected period clocks, expected high clocks}
   localparam logic [51:0] VEC [0:8] = '{
      {8'd9, 8'd5,   2'd2, 2'd0, 16'd40,  16'd22},
      {8'd9, 8'd2,   2'd1, 2'd1, 16'd160, 16'd36},
      {8'd4, 8'd3,   2'd0, 2'd2, 16'd320, 16'd192},
      {8'd4, 8'd1,   2'd3, 2'd3, 16'd320, 16'd112},
      {8'd7, 8'd0,   2'd0, 2'd0, 16'd32,  16'd0},
      {8'd7, 8'd8,   2'd0, 2'd0, 16'd32,  16'd32},
      {8'd7, 8'd200, 2'd0, 2'd1, 16'd128, 16'd128},
      {8'd0, 8'd0,   2'd2, 2'd0, 16'd4,   16'd2},
      {8'd7, 8'd7,   2'd3, 2'd0, 16'd32,  16'd31}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s act=%0d exp=%0d (t=%0t edge=%0d)", req, act, exp, $time, edge_n);
      end
   endtask

   task automatic tick1();
      @(posedge clk);
      #1;
      edge_n++;
   endtask

   task automatic step_to(input int target);
      while (edge_n < target) tick1();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      edge_n = 0;
   endtask

   task automatic run_vec(input int i);
      logic [51:0] v;
      int per, hexp, pre_hi, c1, c2, first;
      string req;
      v = VEC[i];
      period_i  = v[51:44];
      duty_hi_i = v[43:36];
      duty_lo_i = v[35:34];
      psc_sel_i = v[33:32];
      per  = int'(v[31:16]);
      hexp = int'(v[15:0]);
      ctrl_i = 4'h1;
      run_i  = 1'b1;
      do_reset();
      pre_hi = 0; c1 = 0; c2 = 0; first = -1;
      for (int e = 1; e < 3 * per; e++) begin
         tick1();
         if (pwm_o) begin
            if (first < 0) first = e;
            if (e < per) pre_hi++;
            else if (e < 2 * per) c1++;
            else c2++;
         end
      end
      req = (hexp == 0) ? "R4" : (hexp == per) ? "R5" : "R3 R7";
      chk(pre_hi == 0, "R10 low before first boundary", pre_hi, 0);
      if (hexp > 0) chk(first == per, "R2 R7 first rise", first, per);
      chk(c1 == hexp, req, c1, hexp);
      chk(c2 == hexp, req, c2, hexp);
      chk(shadow_o == {v[43:36], v[35:34]}, "R6 shadow", int'(shadow_o),
          int'({v[43:36], v[35:34]}));
   endtask

   task automatic cfg_base();
      period_i = 8'd9; duty_hi_i = 8'd5; duty_lo_i = 2'd2; psc_sel_i = 2'd0;
      ctrl_i = 4'h1; run_i = 1'b1;
   endtask

   initial begin
      // R1: reset state with live inputs
      cfg_base();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk(pwm_o == 1'b0, "R1 pwm", pwm_o, 0);
      chk(pin_oe_o == 1'b0, "R1 oe", pin_oe_o, 0);
      chk(shadow_o == 10'd0, "R1 shadow", int'(shadow_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      edge_n = 0;
      tick1();
      chk(pin_oe_o == 1'b1, "R8 oe after enable", pin_oe_o, 1);
      chk(pwm_o == 1'b0 && shadow_o == 10'd0, "R1 first cycle", int'(shadow_o), 0);

      // table walk
      for (int i = 0; i < 9; i++) run_vec(i);

      // R6: mid-period duty change applies at the next boundary
      cfg_base();
      do_reset();
      step_to(40);
      chk(shadow_o == 10'd22 && pwm_o, "R6 load at boundary", int'(shadow_o), 22);
      step_to(45);
      duty_hi_i = 8'd1; duty_lo_i = 2'd0;
      step_to(61);
      chk(pwm_o == 1'b1, "R6 old duty still high", pwm_o, 1);
      chk(shadow_o == 10'd22, "R6 shadow unchanged", int'(shadow_o), 22);
      step_to(62);
      chk(pwm_o == 1'b0, "R6 old duty fall", pwm_o, 0);
      step_to(79);
      chk(shadow_o == 10'd22, "R6 shadow before boundary", int'(shadow_o), 22);
      step_to(80);
      chk(shadow_o == 10'd4 && pwm_o, "R6 new duty loaded", int'(shadow_o), 4);
      step_to(83);
      chk(pwm_o == 1'b1, "R3 new duty high", pwm_o, 1);
      step_to(84);
      chk(pwm_o == 1'b0, "R3 new duty fall", pwm_o, 0);

      // R8: release and reacquire the pin
      cfg_base();
      do_reset();
      step_to(42);
      chk(pwm_o == 1'b1, "R8 high before release", pwm_o, 1);
      ctrl_i = 4'h0;
      step_to(43);
      chk(pin_oe_o == 1'b0, "R8 oe released", pin_oe_o, 0);
      chk(pwm_o == 1'b0, "R8 pwm released", pwm_o, 0);
      step_to(45);
      ctrl_i = 4'h8;
      step_to(46);
      chk(pin_oe_o == 1'b1, "R8 oe back", pin_oe_o, 1);
      chk(pwm_o == 1'b0, "R8 no resume mid-period", pwm_o, 0);
      step_to(79);
      chk(pwm_o == 1'b0, "R8 low until boundary", pwm_o, 0);
      step_to(80);
      chk(pwm_o == 1'b1, "R8 high at boundary", pwm_o, 1);

      // R9: freeze and resume
      cfg_base();
      do_reset();
      step_to(45);
      run_i = 1'b0;
      step_to(145);
      chk(pwm_o == 1'b1, "R9 pwm held", pwm_o, 1);
      chk(shadow_o == 10'd22, "R9 shadow held", int'(shadow_o), 22);
      run_i = 1'b1;
      step_to(161);
      chk(pwm_o == 1'b1, "R9 resumed high", pwm_o, 1);
      step_to(162);
      chk(pwm_o == 1'b0, "R9 resumed fall", pwm_o, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R2 act=%0d exp=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule